// File: doc/BRIEF.md
# Message Interrupt Remapping Unit

This block sits between real I/O devices and the processors' interrupt delivery logic. A device's message-signalled interrupt write reaches it carrying only two items: the 16-bit requester ID of the device and a small message identifier. The write carries no vector and no destination. The block finds those attributes itself. It walks a two-level table in memory (a root table indexed by the bus byte of the requester ID, then a context table indexed by the device/function byte) to find that device's interrupt remapping table. It then reads the table entry selected by the message identifier and emits the vector and destination processor stored there.

The block accepts one request at a time through a valid/ready handshake. Memory is reached through a simple request/response read port. A four-entry cache of completed translations is tagged by requester ID and message identifier, replaced least-recently-used, and cleared by a global invalidate pulse from the monitor software. It answers repeated interrupts without touching memory. When a lookup fails, the interrupt is dropped and a single-cycle fault record carries the cause, the requester ID and the message identifier.

Top module: `irq_remap`

## Requirements
- R1: After reset, out_valid, fault_valid and mem_req are low and in_ready is high.
- R2: in_ready is high only while no request is in progress. A request is taken on a clock edge with in_valid and in_ready both high, and in_ready stays low from the cycle after that edge until its result has been issued.
- R3: A miss reads exactly three words, in order, each as a one-cycle mem_req pulse. The first is the root word at ROOT_BASE + rid[15:8]: bit 0 is present and bits [AW+15:16] are the context table base. The second is the context word at that base + rid[7:0]: bit 0 is present, bits [AW+15:16] are the remapping table base and bits [15:4] are the table size in entries. The third is the remapping entry at that base + message identifier: bit 0 is present, bits [15:8] are the vector and bits [16+DEST_W-1:16] are the destination.
- R4: A successful translation raises out_valid for exactly one cycle, with out_vector and out_dest taken from the remapping entry.
- R5: A failed lookup raises fault_valid for one cycle with fault_rid and fault_msgid of the request. fault_cause is 0 for an absent root word, 1 for an absent context word, 2 for a message identifier greater than or equal to the table size, and 3 for an absent remapping entry. No read follows the word that failed.
- R6: A request whose requester ID and message identifier match a cached translation is answered with no memory read, with out_valid high in the second cycle after the accepting edge.
- R7: The cache tag holds both the requester ID and the message identifier: the same identifier from another device misses.
- R8: The cache holds four translations. When all four are valid, a fill replaces the least recently used one, where both a hit and a fill count as a use.
- R9: An inval pulse clears every cached translation. An inval in the same cycle as a fill leaves that translation uncached.
- R10: Failed lookups are never cached: repeating a faulting request walks the tables again.
- R11: Each accepted request produces exactly one of out_valid or fault_valid, never both in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming interrupt write present |
| in_ready | output | 1 | Block can take a request |
| in_rid | input | 16 | Requester ID (bus in [15:8], device/function in [7:0]) |
| in_msgid | input | MID_W | Message identifier |
| inval | input | 1 | Global cache invalidate pulse |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data returned, at least one cycle after mem_req |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Remapped interrupt pulse |
| out_vector | output | 8 | Interrupt vector |
| out_dest | output | DEST_W | Destination processor ID |
| fault_valid | output | 1 | Fault record pulse |
| fault_cause | output | 2 | Fault cause code |
| fault_rid | output | 16 | Requester ID of the failed request |
| fault_msgid | output | MID_W | Message identifier of the failed request |

## Verification
The bench builds the block with AW=10, MID_W=6, DEST_W=8 and ROOT_BASE=0. This puts the whole table space into a 1024-word memory model that returns data two cycles after each request. With six identifier bits, a context size of 8 can be probed just inside and just outside its limit. Fault cases 2 and 3 can sit in a table next to good entries. Five identifiers under one device overflow the four-entry cache, so the least-recently-used victim can be identified by counting memory reads. An invalidate pulse placed exactly on the fill edge can also be reached.

// File: rtl/irq_remap.sv
module irq_remap #(
  parameter int AW = 16,
  parameter int MID_W = 8,
  parameter int DEST_W = 8,
  parameter logic [AW-1:0] ROOT_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_rid,
  input  logic [MID_W-1:0]  in_msgid,
  input  logic              inval,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_vector,
  output logic [DEST_W-1:0] out_dest,
  output logic              fault_valid,
  output logic [1:0]        fault_cause,
  output logic [15:0]       fault_rid,
  output logic [MID_W-1:0]  fault_msgid
);
  localparam int WAYS = 4;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_ROOT, S_CTX, S_IRT} state_t;
  state_t st;

  logic [15:0]      rid_q;
  logic [MID_W-1:0] mid_q;

  logic              c_val [WAYS];
  logic [15:0]       c_rid [WAYS];
  logic [MID_W-1:0]  c_mid [WAYS];
  logic [7:0]        c_vec [WAYS];
  logic [DEST_W-1:0] c_dst [WAYS];
  logic [1:0]        c_age [WAYS];

  logic       hit, found;
  logic [1:0] hit_way, victim, use_way;
  logic       take_hit, fill, touch;
  logic       unused_bits;

  wire present = mem_rdata[0];
  wire [AW-1:0] next_base = mem_rdata[AW+15:16];

  assign in_ready    = (st == S_IDLE);
  assign fault_rid   = rid_q;
  assign fault_msgid = mid_q;
  assign unused_bits = ^mem_rdata;

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (c_val[i] && c_rid[i] == rid_q && c_mid[i] == mid_q) begin
        hit = 1'b1;
        hit_way = 2'(i);
      end
  end

  always_comb begin
    found = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++)
      if (!c_val[i] && !found) begin
        found = 1'b1;
        victim = 2'(i);
      end
    if (!found)
      for (int i = 0; i < WAYS; i++)
        if (c_age[i] == 2'd3) victim = 2'(i);
  end

  assign take_hit = (st == S_LOOK) && hit;
  assign fill     = (st == S_IRT) && mem_rvalid && present;
  assign touch    = take_hit || fill;
  assign use_way  = take_hit ? hit_way : victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rid_q <= '0;
      mid_q <= '0;
      mem_req <= 1'b0;
      mem_addr <= '0;
      out_valid <= 1'b0;
      out_vector <= '0;
      out_dest <= '0;
      fault_valid <= 1'b0;
      fault_cause <= '0;
    end else begin
      mem_req <= 1'b0;
      out_valid <= 1'b0;
      fault_valid <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          rid_q <= in_rid;
          mid_q <= in_msgid;
          st <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          out_valid <= 1'b1;
          out_vector <= c_vec[hit_way];
          out_dest <= c_dst[hit_way];
          st <= S_IDLE;
        end else begin
          mem_req <= 1'b1;
          mem_addr <= ROOT_BASE + AW'(rid_q[15:8]);
          st <= S_ROOT;
        end
        S_ROOT: if (mem_rvalid) begin
          if (!present) begin
            fault_valid <= 1'b1;
            fault_cause <= 2'd0;
            st <= S_IDLE;
          end else begin
            mem_req <= 1'b1;
            mem_addr <= next_base + AW'(rid_q[7:0]);
            st <= S_CTX;
          end
        end
        S_CTX: if (mem_rvalid) begin
          if (!present) begin
            fault_valid <= 1'b1;
            fault_cause <= 2'd1;
            st <= S_IDLE;
          end else if (12'(mid_q) >= mem_rdata[15:4]) begin
            fault_valid <= 1'b1;
            fault_cause <= 2'd2;
            st <= S_IDLE;
          end else begin
            mem_req <= 1'b1;
            mem_addr <= next_base + AW'(mid_q);
            st <= S_IRT;
          end
        end
        S_IRT: if (mem_rvalid) begin
          if (!present) begin
            fault_valid <= 1'b1;
            fault_cause <= 2'd3;
          end else begin
            out_valid <= 1'b1;
            out_vector <= mem_rdata[15:8];
            out_dest <= mem_rdata[16 +: DEST_W];
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) begin
        c_val[i] <= 1'b0;
        c_rid[i] <= '0;
        c_mid[i] <= '0;
        c_vec[i] <= '0;
        c_dst[i] <= '0;
        c_age[i] <= 2'(i);
      end
    end else begin
      if (touch)
        for (int i = 0; i < WAYS; i++)
          if (2'(i) == use_way) c_age[i] <= 2'd0;
          else if (c_age[i] < c_age[use_way]) c_age[i] <= c_age[i] + 2'd1;
      if (fill) begin
        c_rid[victim] <= rid_q;
        c_mid[victim] <= mid_q;
        c_vec[victim] <= mem_rdata[15:8];
        c_dst[victim] <= mem_rdata[16 +: DEST_W];
      end
      for (int i = 0; i < WAYS; i++)
        if (inval) c_val[i] <= 1'b0;
        else if (fill && 2'(i) == victim) c_val[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_remap_chk.sv
module irq_remap_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic mem_req,
  input logic out_valid,
  input logic fault_valid
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_read_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_out_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);
  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && fault_valid));
endmodule

bind irq_remap irq_remap_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_req(mem_req), .out_valid(out_valid), .fault_valid(fault_valid)
);

// File: tb/test_irq_remap.sv
module test_irq_remap;
  localparam int AW = 10;
  localparam int MID_W = 6;
  localparam int DEST_W = 8;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, inval = 0;
  logic [15:0] in_rid = 0;
  logic [MID_W-1:0] in_msgid = 0;
  logic mem_req, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic out_valid, fault_valid;
  logic [7:0] out_vector;
  logic [DEST_W-1:0] out_dest;
  logic [1:0] fault_cause;
  logic [15:0] fault_rid;
  logic [MID_W-1:0] fault_msgid;

  irq_remap #(.AW(AW), .MID_W(MID_W), .DEST_W(DEST_W), .ROOT_BASE('0)) i_irq_remap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rid(in_rid), .in_msgid(in_msgid), .inval(inval),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_vector(out_vector), .out_dest(out_dest),
    .fault_valid(fault_valid), .fault_cause(fault_cause),
    .fault_rid(fault_rid), .fault_msgid(fault_msgid));

  always #5 clk = ~clk;

  logic [31:0] mem [0:1023];
  int nreads = 0, pend = 0, vectors = 0, errors = 0, cycles = 0;
  logic [AW-1:0] paddr = 0;
  bit done = 0;

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (pend != 0) begin
      pend--;
      if (pend == 0) begin mem_rvalid = 1; mem_rdata = mem[paddr]; end
    end
    if (mem_req) begin pend = LAT; paddr = mem_addr; nreads++; end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int base, input int mid, input bit p);
    return {6'(0), 10'(base), 4'(0), 8'(mid), 3'(0), p};
  endfunction

  function automatic logic [31:0] ent(input int vec, input int dst, input bit p);
    return {8'(0), 8'(dst), 8'(vec), 7'(0), p};
  endfunction

  function automatic int exp_vec(input int devfn, input int m);
    return devfn == 2 ? 'h40 + m : devfn == 3 ? 'h80 + m : 'hC0 + m;
  endfunction
  function automatic int exp_dst(input int devfn, input int m);
    return devfn == 2 ? m + 1 : devfn == 3 ? 'h20 + m : 'h30;
  endfunction

  bit   g_out, g_flt, g_busy;
  int   g_vec, g_dst, g_cause, g_rid, g_mid, g_lat, g_reads;

  task automatic xact(input logic [15:0] rid, input int mid, input int inval_at);
    int r0;
    int cyc;
    r0 = nreads;
    g_out = 0; g_flt = 0; g_busy = 1; g_lat = 0;
    @(negedge clk);
    in_valid = 1; in_rid = rid; in_msgid = MID_W'(mid);
    @(posedge clk); #1 in_valid = 0;
    cyc = 0;
    while (!g_out && !g_flt && cyc < 60) begin
      @(negedge clk);
      cyc++;
      inval = (cyc == inval_at);
      if (cyc == 1) g_busy = !in_ready;
      if (out_valid) begin g_out = 1; g_vec = out_vector; g_dst = out_dest; end
      if (fault_valid) begin
        g_flt = 1; g_cause = fault_cause; g_rid = fault_rid; g_mid = fault_msgid;
      end
    end
    @(posedge clk); #1 inval = 0;
    g_lat = cyc;
    g_reads = nreads - r0;
  endtask

  task automatic pulse_inval();
    @(negedge clk); inval = 1;
    @(negedge clk); inval = 0;
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid === 1'b0 && fault_valid === 1'b0, "R1 outputs", {out_valid, fault_valid}, 0);
    chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
  endtask

  task automatic good(input logic [15:0] rid, input int mid, input int reads, input string tag);
    xact(rid, mid, 0);
    chk(g_out && !g_flt, {tag, " R4 R11 result"}, {g_out, g_flt}, 2);
    chk(g_vec == exp_vec(rid[7:0], mid), {tag, " R4 vector"}, g_vec, exp_vec(rid[7:0], mid));
    chk(g_dst == exp_dst(rid[7:0], mid), {tag, " R4 dest"}, g_dst, exp_dst(rid[7:0], mid));
    chk(g_reads == reads, {tag, " R3 reads"}, g_reads, reads);
  endtask

  task automatic t_basic();
    good(16'h0102, 3, 3, "miss");
    chk(g_busy, "R2 busy during walk", g_busy, 1);
    chk(in_ready === 1'b1, "R2 ready after result", in_ready, 1);
    good(16'h0102, 7, 3, "R3 limit-1");
  endtask

  task automatic t_hit();
    good(16'h0102, 3, 0, "R6 hit");
    chk(g_lat == 2, "R6 hit latency", g_lat, 2);
    good(16'h0103, 3, 3, "R7 other rid");
    good(16'h0103, 3, 0, "R7 rehit");
  endtask

  task automatic bad(input logic [15:0] rid, input int mid, input int cause, input int reads);
    xact(rid, mid, 0);
    chk(g_flt && !g_out, "R5 R11 fault", {g_out, g_flt}, 1);
    chk(g_cause == cause, "R5 cause", g_cause, cause);
    chk(g_rid == rid && g_mid == mid, "R5 record", {g_rid, 8'(g_mid)}, {rid, 8'(mid)});
    chk(g_reads == reads, "R5 reads", g_reads, reads);
  endtask

  task automatic t_faults();
    bad(16'h0702, 1, 0, 1);
    bad(16'h0104, 1, 1, 2);
    bad(16'h0102, 8, 2, 2);
    bad(16'h0105, 2, 2, 2);
    good(16'h0105, 1, 3, "R5 in range");
    bad(16'h0102, 6, 3, 3);
    xact(16'h0102, 6, 0);
    chk(g_flt && g_reads == 3, "R10 fault not cached", g_reads, 3);
  endtask

  task automatic t_inval();
    pulse_inval();
    good(16'h0102, 3, 3, "R9 after inval");
    xact(16'h0102, 5, 10);
    chk(g_out && g_lat == 11, "R9 fill with inval", g_lat, 11);
    good(16'h0102, 5, 3, "R9 inval wins fill");
  endtask

  task automatic t_lru();
    pulse_inval();
    for (int m = 0; m < 4; m++) good(16'h0103, m, 3, "R8 fill");
    good(16'h0103, 0, 0, "R8 touch");
    good(16'h0103, 4, 3, "R8 fifth");
    good(16'h0103, 0, 0, "R8 kept recent");
    good(16'h0103, 2, 0, "R8 kept");
    good(16'h0103, 3, 0, "R8 kept");
    good(16'h0103, 4, 0, "R8 new");
    good(16'h0103, 1, 3, "R8 lru evicted");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    mem[1] = word('h100, 0, 1);
    mem['h102] = word('h200, 8, 1);
    mem['h103] = word('h240, 16, 1);
    mem['h105] = word('h280, 2, 1);
    for (int m = 0; m < 16; m++) begin
      mem['h200 + m] = ent(exp_vec(2, m), exp_dst(2, m), m != 6);
      mem['h240 + m] = ent(exp_vec(3, m), exp_dst(3, m), 1);
    end
    for (int m = 0; m < 2; m++) mem['h280 + m] = ent(exp_vec(5, m), exp_dst(5, m), 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hit();
    t_faults();
    t_inval();
    t_lru();
    repeat (3) @(posedge clk);
    summary();
  end
endmodule